// File: doc/BRIEF.md
# Bad-Block Logical-to-Physical Remapper

This block translates the logical block numbers used by a host into physical block numbers of a block-erasable flash array. After reset it takes in one good/bad flag for every physical block. It skips the flagged blocks and physical block 0, which is kept for table and boot data. It hands the remaining good blocks to logical numbers in rising order. Any good blocks left over form a pool of hidden spares.

When a mapped block starts to fail, the host raises a retire request for its logical number. If a spare exists, the block takes the lowest-numbered one and raises a copy request to an external engine, naming the old and the new physical block. It swaps the table entry only when that engine acknowledges. Until then, lookups of the affected logical block report busy. If no spare is left, the logical block is removed from the table and the advertised capacity drops by one.

Top module: `bad_block_remapper`

## Requirements
- R1: After reset, `initDone` is 0 and one flag is consumed on each cycle where `scanValid` is 1, for physical blocks 0, 1, 2, ... in turn. `initDone` rises on the cycle after the flag of the last physical block and then stays high. Before that, retire requests are ignored and lookups return `resValid` = 0.
- R2: Physical block 0 is never mapped, never a spare and never named in a copy request, whatever its scan flag says (`scanBad` = 1 means bad).
- R3: Logical block i is mapped to the (i+1)-th good physical block above 0, for i below NUM_LOG. `capacity` equals the number of mapped logical blocks.
- R4: Good blocks that are not mapped become spares. A retire always takes the lowest-numbered spare.
- R5: A lookup returns its result one cycle later: `resValid` = 1 with `resPhys`, or `resValid` = 0 with `resPhys` = 0 when the logical number is unmapped or at least NUM_LOG. The result shows the table as it stood before the edge that samples the lookup.
- R6: Retiring a mapped logical block while a spare exists raises `copyReq` on the next cycle. `copyOldPhys` is the current mapping and `copyNewPhys` the chosen spare, and both hold steady until `copyAck`. At that edge the mapping becomes the new block and `copyReq` drops.
- R7: While a copy is pending, a lookup of the retiring logical block returns `resBusy` = 1 and `resValid` = 0. Other logical blocks resolve normally.
- R8: A retire request is ignored while a copy is pending, and also when it names an unmapped or out-of-range logical block. A `copyAck` with no pending copy is ignored.
- R9: Retiring a mapped logical block with no spare left raises no copy request. It unmaps the block and lowers `capacity` by one.
- R10: `exhausted` is 1 exactly when initialisation is done and no spare remains.
- R11: `capacity` never rises after initialisation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| scanValid | input | 1 | Scan flag present this cycle |
| scanBad | input | 1 | Current physical block is factory-bad |
| initDone | output | 1 | Scan finished, table live |
| lookupValid | input | 1 | Lookup request |
| lookupLog | input | LW | Logical block to translate |
| resValid | output | 1 | Lookup result is a valid mapping |
| resBusy | output | 1 | Looked-up block is mid-copy |
| resPhys | output | PW | Physical block of the lookup |
| retireReq | input | 1 | Retire request |
| retireLog | input | LW | Logical block to retire |
| copyReq | output | 1 | Copy to the new block is pending |
| copyOldPhys | output | PW | Failing source block |
| copyNewPhys | output | PW | Assigned spare block |
| copyAck | input | 1 | Copy engine finished |
| capacity | output | CW | Usable logical blocks |
| exhausted | output | 1 | Spare pool empty |

## Verification
A lookup can land on the same edge as either a retire or a copy acknowledge for the same logical block. The bench provokes both. A lookup issued alongside the retire must return the old physical block as valid. A lookup issued alongside the acknowledge must still report busy, and a lookup on the following cycle must show the new block. Each result is checked against a table that the bench rebuilds from the scan pattern.

// File: rtl/bbr_pkg.sv
package bbr_pkg;

  typedef struct packed {
    logic mapGood;
    logic poolGood;
    logic startCopy;
    logic commitCopy;
    logic dropEntry;
  } bbr_strobe_t;

  typedef enum logic [1:0] {
    ST_SCAN  = 2'd0,
    ST_READY = 2'd1,
    ST_COPY  = 2'd2
  } bbr_state_t;

endpackage

// File: rtl/bbr_ctrl.sv
module bbr_ctrl
  import bbr_pkg::*;
#(
  parameter int NUM_PHYS = 16,
  parameter int NUM_LOG  = 10,
  localparam int PW = $clog2(NUM_PHYS),
  localparam int LW = $clog2(NUM_LOG)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          scanValid,
  input  logic          scanBad,
  input  logic          retireReq,
  input  logic [LW-1:0] retireLog,
  input  logic          copyAck,
  input  logic          retireMapped,
  input  logic          spareAvail,
  input  logic          mapFull,
  output bbr_strobe_t   strb,
  output logic [PW-1:0] scanIdx,
  output logic          pendActive,
  output logic [LW-1:0] pendLog,
  output logic          initDone,
  output logic          copyReq
);

  localparam logic [PW-1:0] LAST_PHYS = PW'(NUM_PHYS - 1);

  bbr_state_t state, nextState;

  always_comb begin
    strb      = '0;
    nextState = state;
    case (state)
      ST_SCAN: begin
        if (scanValid) begin
          if (scanIdx != '0 && !scanBad) begin
            if (!mapFull) strb.mapGood  = 1'b1;
            else          strb.poolGood = 1'b1;
          end
          if (scanIdx == LAST_PHYS) nextState = ST_READY;
        end
      end
      ST_READY: begin
        if (retireReq && retireMapped) begin
          if (spareAvail) begin
            strb.startCopy = 1'b1;
            nextState      = ST_COPY;
          end else begin
            strb.dropEntry = 1'b1;
          end
        end
      end
      ST_COPY: begin
        if (copyAck) begin
          strb.commitCopy = 1'b1;
          nextState       = ST_READY;
        end
      end
      default: nextState = ST_SCAN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_SCAN;
      scanIdx <= '0;
      pendLog <= '0;
    end else begin
      state <= nextState;
      if (state == ST_SCAN && scanValid) scanIdx <= scanIdx + 1'b1;
      if (strb.startCopy) pendLog <= retireLog;
    end
  end

  assign pendActive = (state == ST_COPY);
  assign copyReq    = (state == ST_COPY);
  assign initDone   = (state != ST_SCAN);

endmodule

// File: rtl/bbr_datapath.sv
module bbr_datapath
  import bbr_pkg::*;
#(
  parameter int NUM_PHYS = 16,
  parameter int NUM_LOG  = 10,
  localparam int PW = $clog2(NUM_PHYS),
  localparam int LW = $clog2(NUM_LOG),
  localparam int CW = $clog2(NUM_LOG + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  bbr_strobe_t   strb,
  input  logic [PW-1:0] scanIdx,
  input  logic [LW-1:0] retireLog,
  input  logic [LW-1:0] pendLog,
  input  logic          pendActive,
  input  logic          initDone,
  input  logic          lookupValid,
  input  logic [LW-1:0] lookupLog,
  output logic          retireMapped,
  output logic          spareAvail,
  output logic          mapFull,
  output logic [PW-1:0] copyOldPhys,
  output logic [PW-1:0] copyNewPhys,
  output logic          resValid,
  output logic          resBusy,
  output logic [PW-1:0] resPhys,
  output logic [CW-1:0] capacity,
  output logic          exhausted
);

  logic [PW-1:0]       mapPhys [NUM_LOG];
  logic [NUM_LOG-1:0]  mapValid;
  logic [NUM_PHYS-1:0] spareMask;
  logic [CW-1:0]       nextLog;
  logic [PW-1:0]       lowSpare;

  // one register slot per logical block
  for (genvar e = 0; e < NUM_LOG; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        mapPhys[e]  <= '0;
        mapValid[e] <= 1'b0;
      end else begin
        if (strb.mapGood && nextLog == CW'(e)) begin
          mapPhys[e]  <= scanIdx;
          mapValid[e] <= 1'b1;
        end
        if (strb.commitCopy && pendLog == LW'(e)) mapPhys[e] <= copyNewPhys;
        if (strb.dropEntry && retireLog == LW'(e)) mapValid[e] <= 1'b0;
      end
    end
  end

  // lowest-numbered spare; bit 0 is never set
  always_comb begin
    lowSpare = '0;
    for (int i = NUM_PHYS - 1; i >= 1; i--) begin
      if (spareMask[i]) lowSpare = PW'(i);
    end
  end

  logic retireInRange, lookupInRange, lookupMapped, lookupPend;
  logic [PW-1:0] lookupEntry;

  assign retireInRange = {1'b0, retireLog} < (LW+1)'(NUM_LOG);
  assign lookupInRange = {1'b0, lookupLog} < (LW+1)'(NUM_LOG);
  assign retireMapped  = retireInRange && mapValid[retireLog];
  assign lookupMapped  = lookupInRange && mapValid[lookupLog];
  assign lookupEntry   = lookupInRange ? mapPhys[lookupLog] : '0;
  assign lookupPend    = pendActive && (pendLog == lookupLog);
  assign spareAvail    = |spareMask;
  assign mapFull       = (nextLog == CW'(NUM_LOG));
  assign exhausted     = initDone && !spareAvail;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spareMask   <= '0;
      nextLog     <= '0;
      capacity    <= '0;
      copyOldPhys <= '0;
      copyNewPhys <= '0;
    end else begin
      if (strb.mapGood) begin
        nextLog  <= nextLog + 1'b1;
        capacity <= capacity + 1'b1;
      end
      if (strb.poolGood) spareMask[scanIdx] <= 1'b1;
      if (strb.startCopy) begin
        copyOldPhys         <= mapPhys[retireLog];
        copyNewPhys         <= lowSpare;
        spareMask[lowSpare] <= 1'b0;
      end
      if (strb.dropEntry) capacity <= capacity - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid <= 1'b0;
      resBusy  <= 1'b0;
      resPhys  <= '0;
    end else begin
      resValid <= lookupValid && initDone && lookupMapped && !lookupPend;
      resBusy  <= lookupValid && initDone && lookupMapped && lookupPend;
      resPhys  <= (lookupValid && initDone && lookupMapped && !lookupPend)
                  ? lookupEntry : '0;
    end
  end

endmodule

// File: rtl/bad_block_remapper.sv
module bad_block_remapper
  import bbr_pkg::*;
#(
  parameter int NUM_PHYS = 16,
  parameter int NUM_LOG  = 10,
  localparam int PW = $clog2(NUM_PHYS),
  localparam int LW = $clog2(NUM_LOG),
  localparam int CW = $clog2(NUM_LOG + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          scanValid,
  input  logic          scanBad,
  output logic          initDone,
  input  logic          lookupValid,
  input  logic [LW-1:0] lookupLog,
  output logic          resValid,
  output logic          resBusy,
  output logic [PW-1:0] resPhys,
  input  logic          retireReq,
  input  logic [LW-1:0] retireLog,
  output logic          copyReq,
  output logic [PW-1:0] copyOldPhys,
  output logic [PW-1:0] copyNewPhys,
  input  logic          copyAck,
  output logic [CW-1:0] capacity,
  output logic          exhausted
);

  bbr_strobe_t   strb;
  logic [PW-1:0] scanIdx;
  logic [LW-1:0] pendLog;
  logic          pendActive, retireMapped, spareAvail, mapFull;

  bbr_ctrl #(.NUM_PHYS(NUM_PHYS), .NUM_LOG(NUM_LOG)) u_ctrl (
    .clk(clk), .rstN(rstN), .scanValid(scanValid), .scanBad(scanBad),
    .retireReq(retireReq), .retireLog(retireLog), .copyAck(copyAck),
    .retireMapped(retireMapped), .spareAvail(spareAvail), .mapFull(mapFull),
    .strb(strb), .scanIdx(scanIdx), .pendActive(pendActive), .pendLog(pendLog),
    .initDone(initDone), .copyReq(copyReq)
  );

  bbr_datapath #(.NUM_PHYS(NUM_PHYS), .NUM_LOG(NUM_LOG)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .scanIdx(scanIdx),
    .retireLog(retireLog), .pendLog(pendLog), .pendActive(pendActive),
    .initDone(initDone), .lookupValid(lookupValid), .lookupLog(lookupLog),
    .retireMapped(retireMapped), .spareAvail(spareAvail), .mapFull(mapFull),
    .copyOldPhys(copyOldPhys), .copyNewPhys(copyNewPhys),
    .resValid(resValid), .resBusy(resBusy), .resPhys(resPhys),
    .capacity(capacity), .exhausted(exhausted)
  );

endmodule

// File: rtl/bbr_chk.sv
module bbr_chk #(
  parameter int NUM_PHYS = 16,
  parameter int NUM_LOG  = 10,
  localparam int PW = $clog2(NUM_PHYS),
  localparam int CW = $clog2(NUM_LOG + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          initDone,
  input logic          resValid,
  input logic          resBusy,
  input logic [PW-1:0] resPhys,
  input logic          copyReq,
  input logic [PW-1:0] copyOldPhys,
  input logic [PW-1:0] copyNewPhys,
  input logic          copyAck,
  input logic [CW-1:0] capacity,
  input logic          exhausted
);

  // R1
  init_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone);

  // R2
  blk0_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    copyReq |-> (copyOldPhys != '0 && copyNewPhys != '0 && copyOldPhys != copyNewPhys));

  // R2
  blk0_lookup_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> resPhys != '0);

  // R6
  copy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (copyReq && !copyAck) |=> (copyReq && $stable(copyOldPhys) && $stable(copyNewPhys)));

  // R6
  ack_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (copyReq && copyAck) |=> !copyReq);

  // R7
  busy_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(resValid && resBusy));

  // R10
  exh_init_chk: assert property (@(posedge clk) disable iff (!rstN)
    !initDone |-> !exhausted);

  // R11
  cap_mono_chk: assert property (@(posedge clk) disable iff (!rstN)
    (initDone && $past(initDone)) |-> capacity <= $past(capacity));

endmodule

bind bad_block_remapper bbr_chk #(.NUM_PHYS(NUM_PHYS), .NUM_LOG(NUM_LOG)) u_chk (
  .clk(clk), .rstN(rstN), .initDone(initDone), .resValid(resValid),
  .resBusy(resBusy), .resPhys(resPhys), .copyReq(copyReq),
  .copyOldPhys(copyOldPhys), .copyNewPhys(copyNewPhys), .copyAck(copyAck),
  .capacity(capacity), .exhausted(exhausted)
);

// File: tb/bad_block_remapper_bench.sv
`timescale 1ns/1ps
module bad_block_remapper_bench;

  localparam int NP = 16;
  localparam int NL = 10;
  localparam int PW = $clog2(NP);
  localparam int LW = $clog2(NL);
  localparam int CW = $clog2(NL + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scanValid = 1'b0, scanBad = 1'b0;
  logic lookupValid = 1'b0;
  logic [LW-1:0] lookupLog = '0;
  logic retireReq = 1'b0;
  logic [LW-1:0] retireLog = '0;
  logic copyAck = 1'b0;
  logic initDone, resValid, resBusy, copyReq, exhausted;
  logic [PW-1:0] resPhys, copyOldPhys, copyNewPhys;
  logic [CW-1:0] capacity;

  always #4 clk = ~clk;

  bad_block_remapper #(.NUM_PHYS(NP), .NUM_LOG(NL)) u_bad_block_remapper (
    .clk(clk), .rstN(rstN), .scanValid(scanValid), .scanBad(scanBad),
    .initDone(initDone), .lookupValid(lookupValid), .lookupLog(lookupLog),
    .resValid(resValid), .resBusy(resBusy), .resPhys(resPhys),
    .retireReq(retireReq), .retireLog(retireLog), .copyReq(copyReq),
    .copyOldPhys(copyOldPhys), .copyNewPhys(copyNewPhys), .copyAck(copyAck),
    .capacity(capacity), .exhausted(exhausted)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  int expPhys [NL];
  bit expValid [NL];
  bit [NP-1:0] expSpare;
  int expCap;

  task automatic chkEq(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int lowestSpare();
    for (int i = 1; i < NP; i++) if (expSpare[i]) return i;
    return 0;
  endfunction

  task automatic buildModel(bit [NP-1:0] badMask);
    expCap = 0;
    expSpare = '0;
    for (int l = 0; l < NL; l++) begin expValid[l] = 0; expPhys[l] = 0; end
    for (int p = 1; p < NP; p++) begin
      if (!badMask[p]) begin
        if (expCap < NL) begin
          expPhys[expCap] = p; expValid[expCap] = 1; expCap++;
        end else expSpare[p] = 1'b1;
      end
    end
  endtask

  task automatic lookup(int l, output bit v, output bit b, output int ph);
    lookupValid = 1'b1; lookupLog = LW'(l);
    @(negedge clk);
    lookupValid = 1'b0;
    v = resValid; b = resBusy; ph = int'(resPhys);
  endtask

  task automatic sweep(string req);
    bit v, b; int ph;
    for (int l = 0; l < (1 << LW); l++) begin
      bit ev; int ep;
      ev = (l < NL) ? expValid[l] : 1'b0;
      ep = ev ? expPhys[l] : 0;
      lookup(l, v, b, ph);
      chkEq({req, " lookup valid"}, int'(v), int'(ev));
      chkEq({req, " lookup phys"}, ph, ep);
    end
    chkEq({req, " capacity"}, int'(capacity), expCap);
    chkEq("R10 exhausted", int'(exhausted), int'(expSpare == '0));
  endtask

  task automatic runScan(bit [NP-1:0] badMask, bit tryRetire);
    bit v, b; int ph;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chkEq("R1 reset initDone", int'(initDone), 0);
    chkEq("R1 reset capacity", int'(capacity), 0);
    chkEq("R1 reset copyReq", int'(copyReq), 0);
    chkEq("R10 reset exhausted", int'(exhausted), 0);
    lookup(0, v, b, ph);
    chkEq("R1 lookup before scan", int'(v), 0);
    for (int p = 0; p < NP; p++) begin
      if (p % 5 == 2) @(negedge clk);
      if (p == NP - 1) chkEq("R1 initDone before last flag", int'(initDone), 0);
      scanValid = 1'b1; scanBad = badMask[p];
      if (tryRetire && p == 8) begin retireReq = 1'b1; retireLog = '0; end
      @(negedge clk);
      retireReq = 1'b0;
      if (tryRetire && p == 8) chkEq("R1 retire during scan", int'(copyReq), 0);
      scanValid = 1'b0;
    end
    chkEq("R1 initDone after scan", int'(initDone), 1);
    buildModel(badMask);
  endtask

  task automatic doRetire(int l, string req);
    bit mapped, wantCopy;
    int oldP, newP;
    mapped   = (l < NL) && expValid[l];
    wantCopy = mapped && (expSpare != '0);
    oldP = mapped ? expPhys[l] : 0;
    newP = lowestSpare();
    retireReq = 1'b1; retireLog = LW'(l);
    @(negedge clk);
    retireReq = 1'b0;
    chkEq({req, " copyReq"}, int'(copyReq), int'(wantCopy));
    if (wantCopy) begin
      chkEq("R6 copy old", int'(copyOldPhys), oldP);
      chkEq("R4 copy new lowest spare", int'(copyNewPhys), newP);
      repeat (2) @(negedge clk);
      chkEq("R6 copyReq held", int'(copyReq), 1);
      chkEq("R6 new held", int'(copyNewPhys), newP);
      copyAck = 1'b1;
      @(negedge clk);
      copyAck = 1'b0;
      chkEq("R6 copyReq after ack", int'(copyReq), 0);
      expPhys[l] = newP; expSpare[newP] = 1'b0;
    end else if (mapped) begin
      expValid[l] = 0; expCap--;
    end
    chkEq({req, " capacity"}, int'(capacity), expCap);
  endtask

  initial begin
    bit v, b; int ph, oldP, newP;

    // pattern A: block 0 flagged bad (must be ignored), 3 and 7 bad
    runScan(16'h0089, 1'b1);
    chkEq("R2 log0 maps to block 1", expPhys[0], 1);
    sweep("R3 R5 patA");

    // retire of logical 2 with a lookup of it on the same edge
    oldP = expPhys[2]; newP = lowestSpare();
    retireReq = 1'b1; retireLog = 2; lookupValid = 1'b1; lookupLog = 2;
    @(negedge clk);
    retireReq = 1'b0; lookupValid = 1'b0;
    chkEq("R6 copyReq raised", int'(copyReq), 1);
    chkEq("R6 copy old", int'(copyOldPhys), oldP);
    chkEq("R4 copy new", int'(copyNewPhys), newP);
    chkEq("R5 same-edge lookup valid", int'(resValid), 1);
    chkEq("R5 same-edge lookup phys", int'(resPhys), oldP);
    lookup(2, v, b, ph);
    chkEq("R7 busy pending", int'(b), 1);
    chkEq("R7 not valid pending", int'(v), 0);
    lookup(3, v, b, ph);
    chkEq("R7 other valid", int'(v), 1);
    chkEq("R7 other phys", ph, expPhys[3]);
    // second retire while pending: ignored
    retireReq = 1'b1; retireLog = 4;
    @(negedge clk);
    retireReq = 1'b0;
    chkEq("R8 pending retire ignored new", int'(copyNewPhys), newP);
    chkEq("R8 pending retire ignored old", int'(copyOldPhys), oldP);
    // ack with a lookup of the same block on the same edge
    copyAck = 1'b1; lookupValid = 1'b1; lookupLog = 2;
    @(negedge clk);
    copyAck = 1'b0; lookupValid = 1'b0;
    chkEq("R6 copyReq drops at ack", int'(copyReq), 0);
    chkEq("R7 same-edge ack lookup busy", int'(resBusy), 1);
    expPhys[2] = newP; expSpare[newP] = 1'b0;
    lookup(2, v, b, ph);
    chkEq("R6 remapped phys", ph, newP);
    // stray ack
    copyAck = 1'b1;
    @(negedge clk);
    copyAck = 1'b0;
    chkEq("R8 stray ack no copy", int'(copyReq), 0);
    sweep("R8 patA after retire");

    doRetire(0, "R6 retire log0");
    doRetire(9, "R6 retire log9");
    chkEq("R10 exhausted after pool used", int'(exhausted), 1);
    doRetire(5, "R9 drop log5");
    doRetire(5, "R8 dropped again");
    doRetire(12, "R8 out of range");
    sweep("R9 patA final");

    // pattern B: only odd blocks good, fewer than NL
    runScan(16'h5555, 1'b0);
    sweep("R3 patB");
    doRetire(8, "R8 unmapped retire");
    doRetire(0, "R9 drop patB");
    sweep("R9 patB final");

    // pattern C: every block above 0 bad
    runScan(16'hFFFE, 1'b0);
    sweep("R2 patC");

    // pattern D: all good, five spares
    runScan(16'h0000, 1'b0);
    sweep("R4 patD");
    for (int k = 0; k < 6; k++) doRetire(k, "R4 patD retire");
    sweep("R4 patD final");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule